// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Single-Edge Dead Time

This block drives one pulse-width modulated output whose pulse sits symmetrically around the peak of a triangular timebase. An internal counter climbs from 1 to the programmed period value P and falls back to 2, and then the cycle restarts, so one PWM period lasts 2×P−2 counter ticks. The counter only moves on clock cycles where an external prescaler supplies a tick, so one tick can span many clocks.

The output is active while the count is at or above a duty threshold. A programmable dead time removes ticks from the start of the pulse or from its end, as chosen by an edge-select input. A polarity input sets the inactive level. The period, threshold, dead time, edge select and polarity are captured once just after reset. After that they are captured only at the period boundary, so software can write them at any time without tearing a period. The count value, a direction flag and a one-cycle boundary strobe are also brought out, so that other logic can line up with the timebase.

Top module: `cpwm_dt`

## Requirements
- R1: After the first tick, the count follows 1, 2, …, P, P−1, …, 2 and then repeats from 1, with one step per tick. That gives 2×P−2 ticks per period. A programmed period below 2 behaves as 2.
- R2: `down_o` reads 0 while counting up, including the cycle at P, and reads 1 while falling. `bound_o` is high for exactly one clock: the clock in which the count first shows 1 after falling from 2, or after P when P is 2.
- R3: Let C be the duty value, with values below 2 treated as 2. With zero dead time the output is active during the ticks where the count is ≥ C, in both directions. That is 2×(P−C)+1 ticks centred on the peak. If C > P the output never becomes active.
- R4: With `dt_trail_i` = 0 (leading edge) and a dead time of DT, the first DT ticks of the active window are held inactive. The end of the pulse does not move.
- R5: With `dt_trail_i` = 1 (trailing edge), the last DT ticks of the active window are held inactive. The start of the pulse does not move.
- R6: When DT is greater than or equal to the window width 2×(P−C)+1, the output stays inactive for the whole period.
- R7: With `act_low_i` = 1 the output is inverted: it rests high and pulses low.
- R8: Period, duty, dead time, edge select and polarity are sampled on the first clock after reset. After that they are sampled only on the tick that returns the count to 1. Changes made mid-period have no effect until then.
- R9: The count, direction and boundary strobe change only on clocks where `tick_i` is high. The counter does not move on the capture clock just after reset.
- R10: While reset is asserted, the count is 1, `down_o` is 0, `bound_o` is 0 and `pwm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler tick; the counter advances on clocks where it is high |
| period_i | input | CW | Timebase period P (peak count) |
| duty_i | input | CW | Duty threshold C |
| dtime_i | input | CW | Dead time in ticks |
| dt_trail_i | input | 1 | Dead-time edge: 0 leading, 1 trailing |
| act_low_i | input | 1 | Polarity: 0 active high, 1 active low |
| pwm_o | output | 1 | PWM output |
| count_o | output | CW | Current timebase count |
| down_o | output | 1 | Direction flag, 1 while counting down |
| bound_o | output | 1 | One-clock period-boundary strobe |

## Verification
The threshold and dead-time logic is exercised with several setups:
- A mid-range duty with no dead time fixes the basic symmetric window.
- The same duty with a dead time is run once per edge select, which tells apart which side of the window the pulse loses.
- Dead time equal to and above the window width checks the fully suppressed period.
- Duty values of 0, of exactly P and of above P, with periods of 0, 2 and 20, probe the clamping and the window ends.

Ticks arriving once every three clocks show that the counter holds between ticks. A mid-period rewrite of every setting, followed by a check that nothing changes until the count returns to 1, separates boundary capture from immediate use.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Counting direction of the triangular timebase
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cpwm_dir_e;

  // Which side of the pulse loses the dead-time ticks
  typedef enum logic {
    DT_LEAD  = 1'b0,
    DT_TRAIL = 1'b1
  } cpwm_edge_e;

  // Default data width of period, duty and dead-time values
  localparam int unsigned CPWM_DEF_W = 16;

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int unsigned CW = CPWM_DEF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output cpwm_dir_e     dir_o,
  output logic [CW-1:0] per_o,
  output logic          load_o,
  output logic          bound_o
);

  localparam logic [CW-1:0] MIN_PER = CW'(2);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_q, per_d;
  cpwm_dir_e     dir_q, dir_d;
  logic          armed_q, armed_d;
  logic          bnd_q, bnd_d;
  logic          adv, wrap;

  assign adv = tick_i & armed_q;

  // next-state logic
  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (adv) begin
      if ((dir_q == DIR_UP) && (cnt_q < per_q)) begin
        cnt_d = cnt_q + ONE;
      end else if (cnt_q <= MIN_PER) begin
        cnt_d = ONE;
        dir_d = DIR_UP;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
        dir_d = DIR_DOWN;
      end
    end
    load_o  = ~armed_q | wrap;
    armed_d = 1'b1;
    bnd_d   = wrap;
    per_d   = per_q;
    if (load_o) begin
      per_d = (period_i < MIN_PER) ? MIN_PER : period_i;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= ONE;
      per_q   <= MIN_PER;
      dir_q   <= DIR_UP;
      armed_q <= 1'b0;
      bnd_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      dir_q   <= dir_d;
      armed_q <= armed_d;
      bnd_q   <= bnd_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign dir_o   = dir_q;
  assign per_o   = per_q;
  assign bound_o = bnd_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= ONE) && (cnt_q <= per_q));

  // R9
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && $stable(dir_q) && !bnd_q));

  // R2
  bound_from_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_q |-> ($past(cnt_q) <= MIN_PER) && (cnt_q == ONE));

endmodule

// File: rtl/cpwm_cfg_shadow.sv
module cpwm_cfg_shadow
  import cpwm_pkg::*;
#(
  parameter int unsigned CW = CPWM_DEF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] dtime_i,
  input  logic          trail_i,
  input  logic          low_i,
  output logic [CW-1:0] thr_o,
  output logic [CW-1:0] dt_o,
  output cpwm_edge_e    edge_o,
  output logic          low_o
);

  localparam logic [CW-1:0] MIN_THR = CW'(2);

  logic [CW-1:0] thr_q, thr_d;
  logic [CW-1:0] dt_q, dt_d;
  cpwm_edge_e    edge_q, edge_d;
  logic          low_q, low_d;

  // next-state logic
  always_comb begin
    thr_d  = thr_q;
    dt_d   = dt_q;
    edge_d = edge_q;
    low_d  = low_q;
    if (load_i) begin
      thr_d  = (duty_i < MIN_THR) ? MIN_THR : duty_i;
      dt_d   = dtime_i;
      edge_d = trail_i ? DT_TRAIL : DT_LEAD;
      low_d  = low_i;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= MIN_THR;
      dt_q   <= '0;
      edge_q <= DT_LEAD;
      low_q  <= 1'b0;
    end else begin
      thr_q  <= thr_d;
      dt_q   <= dt_d;
      edge_q <= edge_d;
      low_q  <= low_d;
    end
  end

  assign thr_o  = thr_q;
  assign dt_o   = dt_q;
  assign edge_o = edge_q;
  assign low_o  = low_q;

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(thr_q) && $stable(dt_q) && $stable(edge_q) && $stable(low_q)));

endmodule

// File: rtl/cpwm_window.sv
module cpwm_window
  import cpwm_pkg::*;
#(
  parameter int unsigned CW = CPWM_DEF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  cpwm_dir_e     dir_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] thr_i,
  input  logic [CW-1:0] dt_i,
  input  cpwm_edge_e    edge_i,
  output logic          act_o
);

  localparam int unsigned AW = CW + 3;

  logic [AW-1:0] x, c, d, p;
  logic          in_win, near_ok, far_ok, use_near;

  // near_ok: ticks already spent in the window on the rising side exceed DT
  // far_ok : ticks measured from the far end of the window exceed DT
  always_comb begin
    x        = AW'(cnt_i);
    c        = AW'(thr_i);
    d        = AW'(dt_i);
    p        = AW'(per_i);
    in_win   = (c <= p) && (x >= c);
    near_ok  = (x >= (c + d));
    far_ok   = (((p << 1) + AW'(1)) > (x + c + d));
    use_near = (dir_i == DIR_UP) ? (edge_i == DT_LEAD) : (edge_i == DT_TRAIL);
    act_o    = in_win && (use_near ? near_ok : far_ok);
  end

  // R3
  act_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> (cnt_i >= thr_i) && (thr_i <= per_i));

endmodule

// File: rtl/cpwm_dt.sv
module cpwm_dt
  import cpwm_pkg::*;
#(
  parameter int unsigned CW = CPWM_DEF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] dtime_i,
  input  logic          dt_trail_i,
  input  logic          act_low_i,
  output logic          pwm_o,
  output logic [CW-1:0] count_o,
  output logic          down_o,
  output logic          bound_o
);

  logic [CW-1:0] cnt, per, thr, dt;
  cpwm_dir_e     dir;
  cpwm_edge_e    dedge;
  logic          load, low, act;

  cpwm_timebase #(.CW(CW)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .period_i (period_i),
    .cnt_o    (cnt),
    .dir_o    (dir),
    .per_o    (per),
    .load_o   (load),
    .bound_o  (bound_o)
  );

  cpwm_cfg_shadow #(.CW(CW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .duty_i  (duty_i),
    .dtime_i (dtime_i),
    .trail_i (dt_trail_i),
    .low_i   (act_low_i),
    .thr_o   (thr),
    .dt_o    (dt),
    .edge_o  (dedge),
    .low_o   (low)
  );

  cpwm_window #(.CW(CW)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt),
    .dir_i  (dir),
    .per_i  (per),
    .thr_i  (thr),
    .dt_i   (dt),
    .edge_i (dedge),
    .act_o  (act)
  );

  assign pwm_o   = act ^ low;
  assign count_o = cnt;
  assign down_o  = (dir == DIR_DOWN);

  // R3
  bound_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_o |-> !act);

endmodule

// File: tb/cpwm_dt_tb_top.sv
`timescale 1ns/1ps
module cpwm_dt_tb_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic [CW-1:0] period_i = '0;
  logic [CW-1:0] duty_i = '0;
  logic [CW-1:0] dtime_i = '0;
  logic          dt_trail_i = 1'b0;
  logic          act_low_i = 1'b0;
  logic          pwm_o, down_o, bound_o;
  logic [CW-1:0] count_o;

  always #2 clk = ~clk;

  cpwm_dt #(.CW(CW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick_i),
    .period_i   (period_i),
    .duty_i     (duty_i),
    .dtime_i    (dtime_i),
    .dt_trail_i (dt_trail_i),
    .act_low_i  (act_low_i),
    .pwm_o      (pwm_o),
    .count_o    (count_o),
    .down_o     (down_o),
    .bound_o    (bound_o)
  );

  typedef struct {
    int    cnt;
    bit    dn;
    bit    pwm;
    bit    bnd;
    string tcnt;
    string tpwm;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string tag_cnt = "R1";
  string tag_pwm = "R3";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: driver side of the scoreboard, pushes one item per clock
  int mP, mC, mDT, k;
  bit mTrail, mLow, armed, mBnd;

  task automatic model_load();
    mP     = (int'(period_i) < 2) ? 2 : int'(period_i);
    mC     = (int'(duty_i) < 2) ? 2 : int'(duty_i);
    mDT    = int'(dtime_i);
    mTrail = dt_trail_i;
    mLow   = act_low_i;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      armed = 0; k = 0; mLow = 0;
    end else begin
      exp_t e;
      bit   act;
      int   lo, hi;
      mBnd = 0;
      if (!armed) begin
        model_load();
        armed = 1;
      end else if (tick_i) begin
        k++;
        if (k == 2 * mP - 2) begin
          k = 0; mBnd = 1;
          model_load();
        end
      end
      lo = mC - 1;
      hi = 2 * mP - 1 - mC;
      if (mTrail) hi = hi - mDT; else lo = lo + mDT;
      act = (mC <= mP) && (k >= lo) && (k <= hi);
      e.cnt  = (k < mP) ? k + 1 : 2 * mP - 1 - k;
      e.dn   = (k >= mP);
      e.pwm  = act ^ mLow;
      e.bnd  = mBnd;
      e.tcnt = tag_cnt;
      e.tpwm = tag_pwm;
      sb_q.push_back(e);
    end
  end

  // monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tcnt, "count", int'(count_o), e.cnt);
      chk("R2", "down", int'(down_o), int'(e.dn));
      chk("R2", "bound", int'(bound_o), int'(e.bnd));
      chk(e.tpwm, "pwm", int'(pwm_o), int'(e.pwm));
    end
  end

  task automatic setcfg(input int p, input int d, input int dt, input bit tr, input bit lw);
    period_i   = CW'(p);
    duty_i     = CW'(d);
    dtime_i    = CW'(dt);
    dt_trail_i = tr;
    act_low_i  = lw;
  endtask

  task automatic run(input int ncyc, input int div);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      tick_i = ((i % div) == 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    setcfg(6, 4, 0, 0, 0);
    tick_i = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "count", int'(count_o), 1);
    chk("R10", "down", int'(down_o), 0);
    chk("R10", "bound", int'(bound_o), 0);
    chk("R10", "pwm", int'(pwm_o), 0);
    rst_n = 1'b1;
    tag_pwm = "R3"; run(30, 1);
    // changes below take effect at the next boundary (model loads only there)
    tag_pwm = "R4"; setcfg(6, 4, 2, 0, 0); run(40, 1);
    tag_pwm = "R5"; setcfg(6, 4, 2, 1, 0); run(40, 1);
    tag_pwm = "R6"; setcfg(6, 4, 5, 0, 0); run(30, 1);
    setcfg(6, 4, 7, 1, 0); run(30, 1);
    setcfg(6, 4, 4, 1, 0); run(30, 1);
    tag_pwm = "R7"; setcfg(6, 3, 1, 0, 1); run(30, 1);
    tag_cnt = "R9"; tag_pwm = "R9"; setcfg(5, 3, 0, 0, 0); run(90, 3);
    tag_cnt = "R1"; tag_pwm = "R1"; setcfg(2, 2, 0, 0, 0); run(20, 1);
    setcfg(0, 0, 0, 0, 0); run(20, 1);
    tag_pwm = "R3"; setcfg(6, 9, 0, 0, 0); run(30, 1);
    setcfg(20, 3, 4, 0, 0); run(80, 1);
    setcfg(6, 6, 0, 0, 0); run(30, 1);
    setcfg(8, 5, 0, 0, 0); run(40, 1);
    // R8: rewrite everything mid-period, nothing may move until the wrap
    tag_pwm = "R8";
    run(20, 1);
    setcfg(5, 3, 1, 1, 1);
    run(40, 1);
    setcfg(9, 4, 3, 0, 0);
    run(7, 2);
    setcfg(4, 2, 0, 1, 1);
    run(50, 2);
    @(negedge clk);
    finish_run();
  end

endmodule